// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns bytes written by a processor into asynchronous serial frames on a single line. It has a one-entry holding register in front of the shift register, so the next character can be queued while the current one is still leaving the block. When that holding stage is enabled, a stream of characters goes out with exactly one stop bit between frames. The transmit interrupt then tells software that the holding register has room, not that a frame has finished.

Bit timing comes from a one-cycle tick supplied by an external rate generator. Each line bit lasts from one tick to the next. The mode input selects the framing. Mode 0 is the synchronous mode: here the block sends plain 8-bit frames and always runs single-buffered. Mode 1 sends 8-bit frames. Modes 2 and 3 send 9-bit frames, where the extra bit comes from a separate input. With buffering off, the ninth bit is sampled live and the interrupt fires when the stop bit begins, which is the classic single-buffer behaviour.

Top module: `uart_dbtx`

## Requirements
- R1: After reset `tx_o` is 1, `ti_o` is 0 and `ovr_o` is 0, and the line stays high while nothing is queued.
- R2: A frame is one low start bit, then the data bits with bit 0 first, then one high stop bit. Each bit starts on a `baud_tick_i` pulse. Modes 0 and 1 (`mode_i[1]`=0) carry 8 data bits.
- R3: In modes 2 and 3 (`mode_i[1]`=1), a ninth bit goes out between data bit 7 and the stop bit.
- R4: If a byte sits in the holding register when a stop bit ends, the start bit of the next frame begins on that same tick, so there is exactly one stop bit between the frames.
- R5: With buffering on, `ti_o` rises on the tick where the held byte moves into the shift register. That is the same tick where its start bit begins.
- R6: With buffering on, the ninth bit is captured from `bit9_i` in the cycle of the byte write. Later changes to `bit9_i` do not affect that frame.
- R7: With buffering off, the ninth bit is the value of `bit9_i` on the tick where that bit begins.
- R8: With buffering off, `ti_o` rises on the tick where the stop bit begins.
- R9: In mode 0, `dbuf_en_i`=1 has no effect: frames are 8-bit and `ti_o` rises at the stop bit.
- R10: A write while the holding register is full and not being emptied replaces the held byte. It also sets `ovr_o`, which stays at 1 until reset.
- R11: `ti_o` stays at 1 until `clr_ti_i` is pulsed. If a set event and a clear fall in the same cycle, the set wins.
- R12: A write in the same cycle as the holding-to-shift transfer is kept as the next character and does not set `ovr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_tick_i | input | 1 | One-cycle bit-rate pulse |
| wr_i | input | 1 | Data write strobe |
| wr_data_i | input | 8 | Byte to transmit |
| bit9_i | input | 1 | Ninth bit for 9-bit modes |
| dbuf_en_i | input | 1 | Holding-register enable |
| mode_i | input | 2 | 0 synchronous, 1 8-bit, 2 and 3 9-bit |
| clr_ti_i | input | 1 | Clears the transmit interrupt flag |
| ti_o | output | 1 | Transmit interrupt flag |
| ovr_o | output | 1 | Sticky overrun flag |
| tx_o | output | 1 | Serial line output, idles high |

## Verification
On one tick, a stop bit can end at the same moment the processor writes a new byte. That same tick is also where the interrupt is raised while software may be clearing it. The bench queues a second byte, then counts logged ticks from the first frame's start. On the exact cycle the holding register empties into the shifter, it drives a third write together with a clear of the interrupt. The test passes if the interrupt is still set and no overrun is flagged afterwards, and if three frames follow each other with one stop bit apiece.

// File: rtl/uart_dbtx_pkg.sv
package uart_dbtx_pkg;
  typedef enum logic [1:0] {
    MODE_SYNC  = 2'd0,
    MODE_BYTE  = 2'd1,
    MODE_NINE0 = 2'd2,
    MODE_NINE1 = 2'd3
  } tx_mode_e;

  function automatic logic mode_is_nine(tx_mode_e m);
    return (m == MODE_NINE0) || (m == MODE_NINE1);
  endfunction
endpackage

// File: rtl/uart_dbtx_hold.sv
module uart_dbtx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              bit9_i,
  input  logic              load_i,
  output logic              hold_v_o,
  output logic [DATA_W-1:0] hold_d_o,
  output logic              hold_b9_o,
  output logic              ovr_o
);
  logic hold_v_q, ovr_q, b9_q;
  logic [DATA_W-1:0] d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_v_q <= 1'b0;
      d_q      <= '0;
      b9_q     <= 1'b0;
      ovr_q    <= 1'b0;
    end else begin
      if (wr_i) begin
        d_q  <= wr_data_i;
        b9_q <= bit9_i;
      end
      hold_v_q <= wr_i || (hold_v_q && !load_i);
      // replacing an entry that is not leaving this cycle
      if (wr_i && hold_v_q && !load_i) ovr_q <= 1'b1;
    end
  end

  assign hold_v_o  = hold_v_q;
  assign hold_d_o  = d_q;
  assign hold_b9_o = b9_q;
  assign ovr_o     = ovr_q;
endmodule

// File: rtl/uart_dbtx_shift.sv
module uart_dbtx_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              hold_v_i,
  input  logic [DATA_W-1:0] hold_d_i,
  input  logic              hold_b9_i,
  input  logic              nine_i,
  input  logic              dbuf_i,
  input  logic              bit9_live_i,
  output logic              load_o,
  output logic              stop_ent_o,
  output logic              busy_o,
  output logic              tx_o
);
  localparam int CNT_W = $clog2(DATA_W + 3);

  logic              busy_q, tx_q, b9_q;
  logic [CNT_W-1:0]  cnt_q, last_c;
  logic [DATA_W-1:0] sh_q;
  logic              at_last, free_c;

  always_comb begin
    last_c     = nine_i ? CNT_W'(DATA_W + 2) : CNT_W'(DATA_W + 1);
    at_last    = busy_q && (cnt_q == last_c);
    free_c     = !busy_q || at_last;
    load_o     = tick_i && free_c && hold_v_i;
    stop_ent_o = tick_i && busy_q && !at_last && ((cnt_q + 1'b1) == last_c);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      tx_q   <= 1'b1;
      b9_q   <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
    end else if (load_o) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      sh_q   <= hold_d_i;
      b9_q   <= hold_b9_i;
      tx_q   <= 1'b0;
    end else if (tick_i && at_last) begin
      busy_q <= 1'b0;
      tx_q   <= 1'b1;
    end else if (tick_i && busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q < CNT_W'(DATA_W)) begin
        tx_q <= sh_q[0];
        sh_q <= sh_q >> 1;
      end else if (stop_ent_o) begin
        tx_q <= 1'b1;
      end else begin
        // ninth bit: latched copy when buffered, live input otherwise
        tx_q <= dbuf_i ? b9_q : bit9_live_i;
      end
    end
  end

  assign busy_o = busy_q;
  assign tx_o   = tx_q;
endmodule

// File: rtl/uart_dbtx_irq.sv
module uart_dbtx_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic ti_o
);
  logic ti_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ti_q <= 1'b0;
    else if (set_i)  ti_q <= 1'b1;
    else if (clr_i)  ti_q <= 1'b0;
  end

  assign ti_o = ti_q;
endmodule

// File: rtl/uart_dbtx.sv
module uart_dbtx
  import uart_dbtx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              baud_tick_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              bit9_i,
  input  logic              dbuf_en_i,
  input  logic [1:0]        mode_i,
  input  logic              clr_ti_i,
  output logic              ti_o,
  output logic              ovr_o,
  output logic              tx_o
);
  tx_mode_e          mode;
  logic              nine, dbuf_eff;
  logic              load, stop_ent, busy, hold_v, hold_b9;
  logic [DATA_W-1:0] hold_d;

  assign mode     = tx_mode_e'(mode_i);
  assign nine     = mode_is_nine(mode);
  assign dbuf_eff = dbuf_en_i && (mode != MODE_SYNC);

  uart_dbtx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .wr_data_i (wr_data_i),
    .bit9_i    (bit9_i),
    .load_i    (load),
    .hold_v_o  (hold_v),
    .hold_d_o  (hold_d),
    .hold_b9_o (hold_b9),
    .ovr_o     (ovr_o)
  );

  uart_dbtx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (baud_tick_i),
    .hold_v_i    (hold_v),
    .hold_d_i    (hold_d),
    .hold_b9_i   (hold_b9),
    .nine_i      (nine),
    .dbuf_i      (dbuf_eff),
    .bit9_live_i (bit9_i),
    .load_o      (load),
    .stop_ent_o  (stop_ent),
    .busy_o      (busy),
    .tx_o        (tx_o)
  );

  uart_dbtx_irq u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (dbuf_eff ? load : stop_ent),
    .clr_i  (clr_ti_i),
    .ti_o   (ti_o)
  );
endmodule

// File: rtl/uart_dbtx_chk.sv
module uart_dbtx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic baud_tick_i,
  input logic wr_i,
  input logic clr_ti_i,
  input logic ti_o,
  input logic ovr_o,
  input logic tx_o,
  input logic load,
  input logic stop_ent,
  input logic busy,
  input logic hold_v,
  input logic dbuf_eff
);
  a_r1_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy && !load |=> tx_o);
  a_r2_bit_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !baud_tick_i |=> $stable(tx_o));
  a_r4_start_on_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> !tx_o && busy && !hold_v || (!tx_o && busy && $past(wr_i)));
  a_r5_ti_on_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbuf_eff && load |=> ti_o);
  a_r8_ti_on_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dbuf_eff && stop_ent |=> ti_o && tx_o);
  a_r10_ovr_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && hold_v && !load |=> ovr_o);
  a_r10_ovr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |=> ovr_o);
  a_r11_ti_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ti_o && !clr_ti_i |=> ti_o);
  a_r12_wr_on_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && load && !ovr_o |=> hold_v && !ovr_o);
endmodule

bind uart_dbtx uart_dbtx_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .baud_tick_i (baud_tick_i),
  .wr_i        (wr_i),
  .clr_ti_i    (clr_ti_i),
  .ti_o        (ti_o),
  .ovr_o       (ovr_o),
  .tx_o        (tx_o),
  .load        (load),
  .stop_ent    (stop_ent),
  .busy        (busy),
  .hold_v      (hold_v),
  .dbuf_eff    (dbuf_eff)
);

// File: tb/uart_dbtx_tb.sv
module uart_dbtx_tb;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic wr = 1'b0, b9 = 1'b0, dbuf = 1'b0, clr = 1'b0;
  logic [7:0] wdat = '0;
  logic [1:0] mode = 2'd1;
  logic ti, ovr, tx;

  int n_run = 0, n_fail = 0;
  logic tx_log [0:4095];
  logic ti_log [0:4095];
  int nline = 0;

  int got_d [0:15];
  int got_b9 [0:15];
  int got_st [0:15];
  int got_sp [0:15];
  int got_stopv [0:15];
  int ngot;

  always #4 clk = ~clk;

  uart_dbtx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .baud_tick_i(tick), .wr_i(wr),
    .wr_data_i(wdat), .bit9_i(b9), .dbuf_en_i(dbuf), .mode_i(mode),
    .clr_ti_i(clr), .ti_o(ti), .ovr_o(ovr), .tx_o(tx)
  );

  // tick generator and per-tick line recorder
  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      if (tick && nline < 4096) begin
        tx_log[nline] = tx;
        ti_log[nline] = ti;
        nline++;
      end
      tick = (div == 3);
      div = (div + 1) % 4;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] m, input logic db);
    @(negedge clk); #1;
    rst_n = 1'b0; mode = m; dbuf = db; wr = 0; clr = 0; b9 = 0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic wr_byte(input logic [7:0] d);
    @(negedge clk); #1; wr = 1'b1; wdat = d;
    @(negedge clk); #1; wr = 1'b0;
  endtask

  task automatic wait_ti();
    do begin @(negedge clk); #1; end while (!ti);
  endtask

  task automatic clr_ti();
    @(negedge clk); #1; clr = 1'b1;
    @(negedge clk); #1; clr = 1'b0;
  endtask

  task automatic settle();
    repeat (110) @(negedge clk);
    #1;
  endtask

  task automatic decode(input int base, input bit nine);
    int i = base;
    ngot = 0;
    while (i + 10 + int'(nine) <= nline && ngot < 16) begin
      if (tx_log[i] == 1'b0) begin
        int v = 0;
        for (int k = 0; k < 8; k++) v |= int'(tx_log[i+1+k]) << k;
        got_st[ngot] = i;
        got_d[ngot]  = v;
        got_b9[ngot] = nine ? int'(tx_log[i+9]) : 0;
        got_sp[ngot] = i + 9 + int'(nine);
        got_stopv[ngot] = int'(tx_log[got_sp[ngot]]);
        i = got_sp[ngot] + 1;
        ngot++;
      end else begin
        i++;
      end
    end
  endtask

  task automatic t_reset();
    do_reset(2'd1, 1'b1);
    #1;
    chk(tx == 1'b1, "R1 tx idle", int'(tx), 1);
    chk(ti == 1'b0, "R1 ti reset", int'(ti), 0);
    chk(ovr == 1'b0, "R1 ovr reset", int'(ovr), 0);
    repeat (20) @(negedge clk);
    #1 chk(tx == 1'b1, "R1 tx stays idle", int'(tx), 1);
  endtask

  // R2 R4 R5: buffered 8-bit burst, each next byte written mid-frame
  task automatic t_burst();
    int base;
    int exp [3] = '{8'hA5, 8'h3C, 8'h81};
    do_reset(2'd1, 1'b1);
    base = nline;
    wr_byte(exp[0][7:0]);
    for (int k = 1; k < 3; k++) begin
      wait_ti(); clr_ti(); wr_byte(exp[k][7:0]);
    end
    wait_ti(); clr_ti();
    settle();
    decode(base, 1'b0);
    chk(ngot == 3, "R2 frame count", ngot, 3);
    for (int k = 0; k < 3 && k < ngot; k++) begin
      chk(got_d[k] == exp[k], "R2 data lsb first", got_d[k], exp[k]);
      chk(got_stopv[k] == 1, "R2 stop high", got_stopv[k], 1);
      chk(ti_log[got_st[k]] == 1'b1, "R5 ti at start", int'(ti_log[got_st[k]]), 1);
      if (k > 0) begin
        chk(got_st[k] == got_sp[k-1] + 1, "R4 one stop bit", got_st[k], got_sp[k-1] + 1);
        chk(ti_log[got_st[k]-1] == 1'b0, "R5 ti not early", int'(ti_log[got_st[k]-1]), 0);
      end
    end
  endtask

  // R3 R6: buffered 9-bit, ninth bit latched with the byte
  task automatic t_nine_buf();
    int base;
    do_reset(2'd2, 1'b1);
    base = nline;
    b9 = 1'b1; wr_byte(8'h0F); b9 = 1'b0;
    wait_ti(); clr_ti();
    b9 = 1'b0; wr_byte(8'hF0); b9 = 1'b1;
    wait_ti(); clr_ti();
    settle();
    decode(base, 1'b1);
    chk(ngot == 2, "R3 frame count", ngot, 2);
    if (ngot == 2) begin
      chk(got_d[0] == 8'h0F, "R3 data0", got_d[0], 8'h0F);
      chk(got_b9[0] == 1, "R6 ninth latched 1", got_b9[0], 1);
      chk(got_d[1] == 8'hF0, "R3 data1", got_d[1], 8'hF0);
      chk(got_b9[1] == 0, "R6 ninth latched 0", got_b9[1], 0);
      chk(got_st[1] == got_sp[0] + 1, "R4 one stop bit 9-bit", got_st[1], got_sp[0] + 1);
    end
  endtask

  // R7 R8: unbuffered 9-bit, live ninth bit, ti at stop
  task automatic t_nine_live();
    int base;
    do_reset(2'd3, 1'b0);
    base = nline;
    b9 = 1'b0; wr_byte(8'h5A); b9 = 1'b1;
    wait_ti(); clr_ti();
    b9 = 1'b1; wr_byte(8'h11); b9 = 1'b0;
    wait_ti(); clr_ti();
    settle();
    decode(base, 1'b1);
    chk(ngot == 2, "R7 frame count", ngot, 2);
    if (ngot == 2) begin
      chk(got_d[0] == 8'h5A, "R7 data0", got_d[0], 8'h5A);
      chk(got_b9[0] == 1, "R7 ninth live 1", got_b9[0], 1);
      chk(got_b9[1] == 0, "R7 ninth live 0", got_b9[1], 0);
      for (int k = 0; k < 2; k++) begin
        chk(ti_log[got_sp[k]] == 1'b1, "R8 ti at stop", int'(ti_log[got_sp[k]]), 1);
        chk(ti_log[got_sp[k]-1] == 1'b0, "R8 ti not before stop", int'(ti_log[got_sp[k]-1]), 0);
      end
    end
  endtask

  // R9: mode 0 ignores the buffer enable
  task automatic t_sync_mode();
    int base;
    do_reset(2'd0, 1'b1);
    base = nline;
    b9 = 1'b1; wr_byte(8'hC3);
    wait_ti(); clr_ti();
    settle();
    decode(base, 1'b0);
    chk(ngot == 1, "R9 frame count", ngot, 1);
    if (ngot == 1) begin
      chk(got_d[0] == 8'hC3, "R9 data", got_d[0], 8'hC3);
      chk(got_stopv[0] == 1, "R9 8-bit stop", got_stopv[0], 1);
      chk(ti_log[got_sp[0]] == 1'b1 && ti_log[got_st[0]] == 1'b0, "R9 ti at stop",
          int'(ti_log[got_st[0]]), 0);
    end
  endtask

  // R10: overrun replaces the held byte and sticks
  task automatic t_overrun();
    int base;
    do_reset(2'd1, 1'b1);
    base = nline;
    wr_byte(8'h12);
    wait_ti(); clr_ti();
    wr_byte(8'h34);
    #0 chk(ovr == 1'b0, "R10 no ovr single", int'(ovr), 0);
    wr_byte(8'h56);
    chk(ovr == 1'b1, "R10 ovr set", int'(ovr), 1);
    settle();
    decode(base, 1'b0);
    chk(ngot == 2, "R10 frame count", ngot, 2);
    if (ngot == 2) chk(got_d[1] == 8'h56, "R10 newest kept", got_d[1], 8'h56);
    chk(ovr == 1'b1, "R10 ovr sticky", int'(ovr), 1);
  endtask

  // R11 R12: write and clear land on the transfer cycle
  task automatic t_collide();
    int base, t0;
    do_reset(2'd1, 1'b1);
    base = nline;
    wr_byte(8'h9C);
    wait_ti();
    t0 = nline - 1;
    wr_byte(8'h47);
    do begin @(negedge clk); #1; end while (!(tick && nline == t0 + 10));
    wr = 1'b1; wdat = 8'hE2; clr = 1'b1;
    @(negedge clk); #1; wr = 1'b0; clr = 1'b0;
    chk(ti == 1'b1, "R11 set wins over clear", int'(ti), 1);
    chk(ovr == 1'b0, "R12 no overrun on transfer", int'(ovr), 0);
    clr_ti();
    chk(ti == 1'b0, "R11 clear works", int'(ti), 0);
    settle();
    decode(base, 1'b0);
    chk(ngot == 3, "R12 frame count", ngot, 3);
    if (ngot == 3) begin
      chk(got_d[1] == 8'h47, "R12 second byte", got_d[1], 8'h47);
      chk(got_d[2] == 8'hE2, "R12 colliding byte", got_d[2], 8'hE2);
      chk(got_st[2] == got_sp[1] + 1, "R12 back to back", got_st[2], got_sp[1] + 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_burst();
    t_nine_buf();
    t_nine_live();
    t_sync_mode();
    t_overrun();
    t_collide();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule